// File: doc/BRIEF.md
# Multi-Channel A/D Conversion Sequencer

This block is the digital controller that walks an external A/D conversion engine through a group of analog input channels in a single pass. Software configures it through a small register interface. One control/status word holds the configuration bits, a start bit, a completion flag and an interrupt enable. Each of the eight channels also has its own result register.

A pass begins in one of two ways. Software can write the start bit, or an external trigger pulse can arrive while the stored mode is one-pass multi mode. The sequencer then issues a start pulse and a channel number to the engine. When the engine answers with a done pulse and a result, the sequencer stores the result in that channel's register. In the following cycle it starts the next channel. After the last channel of the selection it sets the completion flag and clears the start bit in the same step, and it raises an interrupt request if enabled. Software can halt a pass by clearing the start bit. A later start always begins again at the first channel of the group.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the control word, every result register, `irq` and `eng_start` read 0.
- R2: Address 8 reads the control word: bits [1:0] count, bit 2 group, bit 3 scan, bit 4 multi, bit 5 interrupt enable, bit 6 start, bit 7 done. Addresses 0 to 7 read the result of channel 0 to 7, zero-extended.
- R3: A pass starts on a control write with start=1, multi=1 and scan=0 while the start bit is 0. It also starts on a one-cycle `ext_trig` pulse while the stored mode is multi=1, scan=0 and the start bit is 0. The first `eng_start` follows one cycle later, on channel group*4.
- R4: A pass converts count+1 channels in ascending order, from group*4 to group*4+count. There is exactly one `eng_start` pulse per channel.
- R5: On each `eng_done` of an active pass, `eng_result` is stored in the current channel's register. If channels remain, the next `eng_start` comes in the very next cycle.
- R6: The `eng_done` of the last channel sets done to 1 and clears start to 0 at the same clock edge.
- R7: `irq` is 1 exactly while done and the interrupt-enable bit are both 1.
- R8: A control write with start=0 during a pass halts it. No further `eng_start` is issued, a later `eng_done` is discarded, and the registers of unreached channels keep their values.
- R9: A start after a halt begins at the first channel of the group.
- R10: A single write that changes group/count and sets start uses the new selection for that pass.
- R11: A start request with multi=0 or scan=1 is ignored. The start bit stays 0 and no `eng_start` is issued, whether the request comes from the write itself or from `ext_trig` with such a stored mode.
- R12: Writing done=0 clears the flag only if the control word was read with `reg_rd` while done was 1 since the flag was last set. Writing done=1 never changes it.
- R13: When a pass ends in the same cycle as a done-clearing write, done ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 4 | Register address (0-7 results, 8 control) |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (arms the done-clear) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| ext_trig | input | 1 | External start trigger, one-cycle synchronous pulse |
| eng_start | output | 1 | One-cycle start pulse to the conversion engine |
| eng_chan | output | 3 | Channel to convert |
| eng_done | input | 1 | One-cycle conversion-complete pulse from the engine |
| eng_result | input | 10 | Conversion result, valid with `eng_done` |
| irq | output | 1 | Interrupt request |

## Verification
The end of a pass and a software write to the control word can land on the same clock edge. In that case the flag set by the sequencer and the flag clear by software contend for the done bit. The bench arms the clear by reading the flag as 1, starts a two-channel pass, and watches for the engine's second done pulse. It drives a done=0 write in that same cycle, so the write and the pass end reach the register on one edge. It then judges from the control word and `irq` that done stayed 1 and start dropped to 0, and that a later unread write of 0 leaves the flag set.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CNT_W     = 2;
  localparam int GRP_W     = 1;
  localparam int CH_W      = CNT_W + GRP_W;
  localparam int NUM_CH    = 1 << CH_W;
  localparam int CTRL_BITS = 8;
  localparam int CTRL_ADDR = 8;

  // Control word, MSB first: done(7) start(6) ie(5) multi(4) scan(3) grp(2) cnt(1:0)
  typedef struct packed {
    logic             done;
    logic             start;
    logic             ie;
    logic             multi;
    logic             scan;
    logic [GRP_W-1:0] grp;
    logic [CNT_W-1:0] cnt;
  } ctrl_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             rd_ctrl,
  input  ctrl_t            wval,
  input  logic             ext_trig,
  input  logic             pass_end,
  output logic             go,
  output logic             stop,
  output logic [GRP_W-1:0] go_grp,
  output logic [CNT_W-1:0] go_cnt,
  output ctrl_t            cur
);
  ctrl_t ctrl_q;
  logic  armed_q;

  logic w_ok, c_ok, sw_go, trig_go;
  logic cfg_en, start_en, start_d;
  logic done_set, done_clr, done_en, done_d;
  logic arm_en, arm_d;

  always_comb begin
    w_ok     = wval.multi & ~wval.scan;
    c_ok     = ctrl_q.multi & ~ctrl_q.scan;
    sw_go    = wr_ctrl & wval.start & w_ok & ~ctrl_q.start;
    trig_go  = ext_trig & ~wr_ctrl & c_ok & ~ctrl_q.start;
    go       = sw_go | trig_go;
    stop     = wr_ctrl & ctrl_q.start & ~(wval.start & w_ok);
    go_grp   = sw_go ? wval.grp : ctrl_q.grp;
    go_cnt   = sw_go ? wval.cnt : ctrl_q.cnt;

    cfg_en   = wr_ctrl;
    start_en = go | stop | pass_end;
    start_d  = go;

    done_set = pass_end;
    done_clr = wr_ctrl & ~wval.done & armed_q & ~pass_end;
    done_en  = done_set | done_clr;
    done_d   = done_set;

    arm_en   = pass_end | done_clr | (rd_ctrl & ctrl_q.done);
    arm_d    = ~pass_end & ~done_clr & rd_ctrl & ctrl_q.done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      if (cfg_en) begin
        ctrl_q.ie    <= wval.ie;
        ctrl_q.multi <= wval.multi;
        ctrl_q.scan  <= wval.scan;
        ctrl_q.grp   <= wval.grp;
        ctrl_q.cnt   <= wval.cnt;
      end
      if (start_en) ctrl_q.start <= start_d;
      if (done_en)  ctrl_q.done  <= done_d;
      if (arm_en)   armed_q      <= arm_d;
    end
  end

  assign cur = ctrl_q;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             stop,
  input  logic [GRP_W-1:0] go_grp,
  input  logic [CNT_W-1:0] go_cnt,
  input  logic             eng_done,
  output logic             eng_start,
  output logic [CH_W-1:0]  eng_chan,
  output logic             busy,
  output logic             res_we,
  output logic [CH_W-1:0]  res_ch,
  output logic             pass_end
);
  logic            busy_q, busy_n;
  logic            est_q, est_n;
  logic [CH_W-1:0] chan_q, chan_n;
  logic [CH_W-1:0] last_q, last_n;
  logic            conv_ok, at_last;

  always_comb begin
    conv_ok  = busy_q & eng_done & ~stop;
    at_last  = (chan_q == last_q);
    pass_end = conv_ok & at_last;
    res_we   = conv_ok;
    res_ch   = chan_q;

    busy_n = busy_q;
    chan_n = chan_q;
    last_n = last_q;
    est_n  = 1'b0;
    if (go) begin
      busy_n = 1'b1;
      chan_n = {go_grp, {CNT_W{1'b0}}};
      last_n = {go_grp, go_cnt};
      est_n  = 1'b1;
    end else if (stop) begin
      busy_n = 1'b0;
    end else if (conv_ok) begin
      if (at_last) begin
        busy_n = 1'b0;
      end else begin
        chan_n = chan_q + 1'b1;
        est_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      est_q  <= 1'b0;
      chan_q <= '0;
      last_q <= '0;
    end else begin
      busy_q <= busy_n;
      est_q  <= est_n;
      chan_q <= chan_n;
      last_q <= last_n;
    end
  end

  assign eng_start = est_q;
  assign eng_chan  = chan_q;
  assign busy      = busy_q;
endmodule

// File: rtl/adc_seq_resbank.sv
module adc_seq_resbank
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [CH_W-1:0]                wch,
  input  logic [RES_W-1:0]               wres,
  output logic [NUM_CH-1:0][RES_W-1:0]   res
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic             en;
    logic [RES_W-1:0] val_q;
    assign en = we & (wch == CH_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  val_q <= '0;
      else if (en) val_q <= wres;
    end
    assign res[i] = val_q;
  end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int RES_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ext_trig,
  output logic              eng_start,
  output logic [CH_W-1:0]   eng_chan,
  input  logic              eng_done,
  input  logic [RES_W-1:0]  eng_result,
  output logic              irq
);
  logic rst_m_q, rst_s_q, rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end
  assign rst_s_n = rst_s_q;

  logic                         is_ctrl, wr_ctrl, rd_ctrl;
  ctrl_t                        wval, ctrl_cur;
  logic                         go, stop, pass_end, busy, res_we;
  logic [GRP_W-1:0]             go_grp;
  logic [CNT_W-1:0]             go_cnt;
  logic [CH_W-1:0]              res_ch;
  logic [NUM_CH-1:0][RES_W-1:0] res;
  logic                         unused_hi;

  assign is_ctrl   = (reg_addr == ADDR_W'(CTRL_ADDR));
  assign wr_ctrl   = reg_wr & is_ctrl;
  assign rd_ctrl   = reg_rd & is_ctrl;
  assign wval      = ctrl_t'(reg_wdata[CTRL_BITS-1:0]);
  assign unused_hi = ^reg_wdata[DATA_W-1:CTRL_BITS];

  adc_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .wr_ctrl  (wr_ctrl),
    .rd_ctrl  (rd_ctrl),
    .wval     (wval),
    .ext_trig (ext_trig),
    .pass_end (pass_end),
    .go       (go),
    .stop     (stop),
    .go_grp   (go_grp),
    .go_cnt   (go_cnt),
    .cur      (ctrl_cur)
  );

  adc_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .go        (go),
    .stop      (stop),
    .go_grp    (go_grp),
    .go_cnt    (go_cnt),
    .eng_done  (eng_done),
    .eng_start (eng_start),
    .eng_chan  (eng_chan),
    .busy      (busy),
    .res_we    (res_we),
    .res_ch    (res_ch),
    .pass_end  (pass_end)
  );

  adc_seq_resbank #(.RES_W(RES_W)) u_res (
    .clk   (clk),
    .rst_n (rst_s_n),
    .we    (res_we),
    .wch   (res_ch),
    .wres  (eng_result),
    .res   (res)
  );

  always_comb begin
    reg_rdata = '0;
    if (is_ctrl)
      reg_rdata[CTRL_BITS-1:0] = ctrl_cur;
    else if (reg_addr < ADDR_W'(NUM_CH))
      reg_rdata[RES_W-1:0] = res[reg_addr[CH_W-1:0]];
  end

  assign irq = ctrl_cur.done & ctrl_cur.ie;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic eng_start,
  input logic [1:0] chan_lo,
  input logic eng_done,
  input logic irq,
  input logic go,
  input logic stop,
  input logic pass_end,
  input logic busy,
  input logic done_f,
  input logic start_f,
  input logic ie_f
);
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && eng_done && !stop && !pass_end |=> eng_start); // R5

  AST_PASS_END_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    pass_end |=> done_f && !start_f); // R6

  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    pass_end |=> (irq == ie_f)); // R7

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !eng_start && !busy); // R8

  AST_FIRST_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> eng_start && (chan_lo == 2'b00)); // R9

  AST_START_IN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> busy); // R4
endmodule

bind adc_seq_top adc_seq_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .eng_start (eng_start),
  .chan_lo   (eng_chan[1:0]),
  .eng_done  (eng_done),
  .irq       (irq),
  .go        (go),
  .stop      (stop),
  .pass_end  (pass_end),
  .busy      (busy),
  .done_f    (ctrl_cur.done),
  .start_f   (ctrl_cur.start),
  .ie_f      (ctrl_cur.ie)
);

// File: tb/adc_seq_tb.sv
module adc_seq_top_tb_top;
  localparam int LAT = 6;

  logic        clk, rst_n;
  logic [3:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [15:0] reg_wdata, reg_rdata;
  logic        ext_trig, eng_start, eng_done, irq;
  logic [2:0]  eng_chan;
  logic [9:0]  eng_result;

  int n_chk = 0, n_err = 0;
  int seed = 0;
  int starts_seen = 0;
  logic [2:0] exp_q[$];
  logic [9:0] exp_res [8];
  logic prev_done = 1'b0;

  adc_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_trig(ext_trig), .eng_start(eng_start), .eng_chan(eng_chan),
    .eng_done(eng_done), .eng_result(eng_result), .irq(irq)
  );

  initial begin clk = 1'b0; forever #4 clk = ~clk; end

  function automatic logic [9:0] res_of(int ch, int s);
    return 10'((ch * 53 + s * 7 + 3) % 1024);
  endfunction

  // engine stand-in: fixed latency, one conversion in flight
  logic       s_busy = 1'b0;
  int         s_cnt = 0;
  logic [2:0] s_ch = '0;
  always @(posedge clk) begin
    eng_done <= 1'b0;
    if (eng_start) begin
      s_busy <= 1'b1; s_cnt <= LAT - 1; s_ch <= eng_chan;
    end else if (s_busy) begin
      if (s_cnt == 0) begin
        eng_done <= 1'b1; eng_result <= res_of(int'(s_ch), seed); s_busy <= 1'b0;
      end else s_cnt <= s_cnt - 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done && exp_q.size() > 0)
        check(eng_start === 1'b1, "R5 next start right after done", int'(eng_start), 1);
      if (eng_start === 1'b1) begin
        starts_seen++;
        if (exp_q.size() == 0) check(0, "R4/R8/R11 unexpected engine start", int'(eng_chan), 0);
        else begin
          logic [2:0] e;
          e = exp_q.pop_front();
          check(eng_chan == e, "R3/R4 start channel", int'(eng_chan), int'(e));
        end
      end
      prev_done = eng_done;
    end
  end

  task automatic push_pass(input bit grp, input int cnt);
    for (int i = 0; i <= cnt; i++) exp_q.push_back({grp, 2'(i)});
  endtask

  task automatic wr_ctrl(input bit dn, ie, st, mu, sc, gr, input logic [1:0] cn);
    @(negedge clk);
    reg_addr = 4'd8; reg_wdata = {8'h00, dn, st, ie, mu, sc, gr, cn}; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, input bit strobe, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = strobe;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_pass();
    int t = 0;
    while (exp_q.size() > 0 && t < 2000) begin @(negedge clk); t++; end
    t = 0;
    do begin @(negedge clk); reg_addr = 4'd8; #1; t++; end
    while (reg_rdata[7] !== 1'b1 && t < 60);
    repeat (2) @(negedge clk);
  endtask

  task automatic update_exp(input bit grp, input int cnt);
    for (int i = 0; i <= cnt; i++) exp_res[{grp, 2'(i)}] = res_of({grp, 2'(i)}, seed);
  endtask

  task automatic check_results(input string tag);
    logic [15:0] v;
    for (int ch = 0; ch < 8; ch++) begin
      rd_reg(4'(ch), 1'b0, v);
      check(v == {6'h0, exp_res[ch]}, tag, int'(v), int'(exp_res[ch]));
    end
  endtask

  task automatic clear_done(input bit ie, mu, sc, gr, input logic [1:0] cn);
    logic [15:0] v;
    rd_reg(4'd8, 1'b1, v);
    wr_ctrl(1'b0, ie, 1'b0, mu, sc, gr, cn);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int base, nd;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0; ext_trig = 1'b0;
    for (int i = 0; i < 8; i++) exp_res[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_reg(4'd8, 1'b0, v);
    check(v == 16'h0, "R1 control after reset", int'(v), 0);
    check(irq == 1'b0 && eng_start == 1'b0, "R1 irq/eng_start after reset", int'({irq, eng_start}), 0);
    check_results("R1 results after reset");

    // R2 R3 R4 R5 R6 R7: software start, group 0, three channels, interrupts on
    seed = 17;
    push_pass(1'b0, 2);
    wr_ctrl(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2);
    wait_pass();
    update_exp(1'b0, 2);
    rd_reg(4'd8, 1'b0, v);
    check(v == 16'h00B2, "R6 done set, start cleared", int'(v), 'hB2);
    check(irq == 1'b1, "R7 irq with done and enable", int'(irq), 1);
    check_results("R2/R5 results of pass 1");

    // R12 done-clear protocol
    wr_ctrl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2);
    rd_reg(4'd8, 1'b0, v);
    check(v[7] == 1'b1, "R12 unread write of 0 keeps done", int'(v[7]), 1);
    rd_reg(4'd8, 1'b1, v);
    wr_ctrl(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2);
    rd_reg(4'd8, 1'b0, v);
    check(v[7] == 1'b1, "R12 write of 1 keeps done", int'(v[7]), 1);
    wr_ctrl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2);
    rd_reg(4'd8, 1'b0, v);
    check(v[7] == 1'b0, "R12 armed write of 0 clears done", int'(v[7]), 0);
    check(irq == 1'b0, "R7 irq drops with done", int'(irq), 0);

    // R3 R4 external trigger, group 1, four channels, interrupts off
    wr_ctrl(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd3);
    seed = 91;
    push_pass(1'b1, 3);
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
    wait_pass();
    update_exp(1'b1, 3);
    rd_reg(4'd8, 1'b0, v);
    check(v == 16'h0097, "R3/R6 trigger pass end word", int'(v), 'h97);
    check(irq == 1'b0, "R7 no irq with enable off", int'(irq), 0);
    check_results("R4 results of trigger pass");

    // R11 non-multi start requests ignored
    clear_done(1'b0, 1'b0, 1'b0, 1'b1, 2'd3);
    base = starts_seen;
    wr_ctrl(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd3);
    rd_reg(4'd8, 1'b0, v);
    check(v[6] == 1'b0, "R11 start with multi=0 ignored", int'(v[6]), 0);
    wr_ctrl(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd3);
    rd_reg(4'd8, 1'b0, v);
    check(v[6] == 1'b0, "R11 start with scan=1 ignored", int'(v[6]), 0);
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
    repeat (LAT + 4) @(negedge clk);
    check(starts_seen == base, "R11 no engine start", starts_seen - base, 0);

    // R8 halt mid-pass
    seed = 200;
    wr_ctrl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd3);
    exp_q.push_back(3'd4); exp_q.push_back(3'd5);
    base = starts_seen;
    wr_ctrl(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd3);
    while (starts_seen < base + 2) @(negedge clk);
    wr_ctrl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd3);
    repeat (LAT + 6) @(negedge clk);
    exp_res[4] = res_of(4, seed);
    rd_reg(4'd8, 1'b0, v);
    check(v[7:6] == 2'b00, "R8 halted: start and done 0", int'(v[7:6]), 0);
    check(starts_seen == base + 2, "R8 no start after halt", starts_seen - base, 2);
    check_results("R8 unreached and late results untouched");

    // R9 restart from first channel of group
    seed = 201;
    push_pass(1'b1, 3);
    wr_ctrl(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd3);
    wait_pass();
    update_exp(1'b1, 3);
    check_results("R9 results after restart");

    // R10 selection change in the starting write
    clear_done(1'b1, 1'b1, 1'b0, 1'b1, 2'd3);
    seed = 55;
    push_pass(1'b0, 0);
    wr_ctrl(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0);
    wait_pass();
    update_exp(1'b0, 0);
    rd_reg(4'd8, 1'b0, v);
    check(v == 16'h0090, "R10 new selection used", int'(v), 'h90);
    check_results("R10 only channel 0 written");

    // R13 pass end and done-clear write on the same edge
    rd_reg(4'd8, 1'b1, v);
    seed = 77;
    push_pass(1'b0, 1);
    wr_ctrl(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1);
    nd = 0;
    while (nd < 2) begin
      @(negedge clk); #1;
      if (eng_done === 1'b1) nd++;
    end
    reg_addr = 4'd8; reg_wdata = 16'h0071; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    repeat (2) @(negedge clk);
    update_exp(1'b0, 1);
    rd_reg(4'd8, 1'b0, v);
    check(v[7:6] == 2'b10, "R13 done wins over clear", int'(v[7:6]), 2);
    check(irq == 1'b1, "R13 irq stays", int'(irq), 1);
    wr_ctrl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1);
    rd_reg(4'd8, 1'b0, v);
    check(v[7] == 1'b1, "R12 clear needs a new read", int'(v[7]), 1);
    check_results("R13 results");
    check(exp_q.size() == 0, "R4 all expected starts seen", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule